// File: doc/BRIEF.md
# Bus Fault Address Capture Unit

This block sits beside a processor's data bus and records where the most recent failed data access went. Whenever an access completes with an error response, its address is latched into a read-only fault address register. Each later fault overwrites the register, so software always sees the latest failure. For a burst write, a slave usually pipelines the data, so the exact failing beat cannot be known. In that case the address is kept only down to the burst boundary, and the bits below that boundary are stored as zero.

Each captured fault also sets a sticky pending flag. The bus-error interrupt line is asserted while that flag is set and software has enabled the interrupt. Software clears the flag by writing a one to it. Registers are reached through a small synchronous port. A read returns its data one cycle after it is issued.

Top module: `bfc_top`

## Requirements
- R1: After a synchronous reset, the fault address register reads 0x00000000, the enable bit and the pending flag read 0, and `irq` is low.
- R2: An access with `acc_valid` and `acc_err` both high is a fault. For a single access (`acc_kind` 0, and also the unused code 3) or a burst read (`acc_kind` 1), the fault address register holds the full access address from the next cycle on. Each new fault replaces the previous address.
- R3: For a faulting burst write (`acc_kind` 2), the stored address has its low `acc_bsize` bits forced to zero. The burst length is 2^`acc_bsize` bytes, so a 16-byte burst uses `acc_bsize` = 4 and clears bits 3:0.
- R4: An access without `acc_err`, or with `acc_valid` low, changes neither the fault address nor the pending flag.
- R5: A register write to offset 0 (the fault address register) has no effect on its contents.
- R6: A fault sets the pending flag (offset 2, bit 0) in the next cycle. `irq` is high exactly when the pending flag is set and the enable bit is set.
- R7: A write to offset 2 with bit 0 = 1 clears the pending flag. A write with bit 0 = 0 leaves the flag unchanged.
- R8: When a fault and a clearing write to offset 2 fall in the same cycle, the fault wins. The flag stays set and the address updates.
- R9: A read (`reg_sel` high, `reg_wr` low) returns its data on `reg_rdata` in the following cycle. That data is the register contents as they stood in the read cycle. Offset 3 reads 0, and `reg_rdata` is 0 in any cycle not following a read.
- R10: The enable register (offset 1, bit 0) is written and read back. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A data access completes this cycle |
| acc_err | input | 1 | The completing access received an error response |
| acc_addr | input | 32 | Address of the completing access |
| acc_kind | input | 2 | 0 single, 1 burst read, 2 burst write, 3 treated as single |
| acc_bsize | input | 3 | Log2 of the burst length in bytes |
| reg_sel | input | 1 | Register port access this cycle |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_off | input | 2 | Register word offset: 0 fault address, 1 enable, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| irq | output | 1 | Bus-error interrupt |

## Verification
Two functions can act on the pending flag in the same cycle: capturing a new fault sets it, and a write-one-to-clear from software resets it. The bench drives a faulting access and a clearing status write together at one clock edge. It then checks that `irq` stays high and that a later read returns the new address with the flag still set. The reverse pairing is also checked: a clear with no fault in the same cycle must drop the flag. Every burst size is swept for both burst reads and burst writes, so that masking is shown to apply only to writes.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    localparam int ADDR_W  = 32;
    localparam int BSIZE_W = 3;
    localparam int OFF_W   = 2;

    typedef enum logic [1:0] {
        XF_SINGLE   = 2'd0,
        XF_BURST_RD = 2'd1,
        XF_BURST_WR = 2'd2,
        XF_RSVD     = 2'd3
    } xfer_kind_e;

    localparam logic [OFF_W-1:0] OFF_FADDR  = 2'd0;
    localparam logic [OFF_W-1:0] OFF_ENABLE = 2'd1;
    localparam logic [OFF_W-1:0] OFF_STATUS = 2'd2;

    typedef struct packed {
        logic                  hit;
        logic [ADDR_W-1:0]     addr;
        xfer_kind_e            kind;
        logic [BSIZE_W-1:0]    bsize;
    } fault_evt_t;

    function automatic logic [ADDR_W-1:0] low_bits_mask(input logic [BSIZE_W-1:0] bsize);
        return (ADDR_W'(1) << bsize) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/bfc_capture.sv
module bfc_capture
    import bfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fault_evt_t        evt,
    output logic [ADDR_W-1:0] fault_addr
);

    logic [ADDR_W-1:0] next_addr;

    always_comb begin
        if (evt.kind == XF_BURST_WR)
            next_addr = evt.addr & ~low_bits_mask(evt.bsize);
        else
            next_addr = evt.addr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fault_addr <= '0;
        else if (evt.hit)
            fault_addr <= next_addr;
    end

    // R4: the register only moves on a fault
    a_r4_hold_without_fault: assert property (@(posedge clk) disable iff (rst)
        !evt.hit |=> $stable(fault_addr));

    // R2: exact capture for non burst-write faults
    a_r2_exact_capture: assert property (@(posedge clk) disable iff (rst)
        (evt.hit && evt.kind != XF_BURST_WR) |=> (fault_addr == $past(evt.addr)));

    // R3: bits below the burst boundary are zero after a burst-write fault
    a_r3_burst_mask: assert property (@(posedge clk) disable iff (rst)
        (evt.hit && evt.kind == XF_BURST_WR) |=>
        ((fault_addr & low_bits_mask($past(evt.bsize))) == '0));

endmodule

// File: rtl/bfc_regs.sv
module bfc_regs
    import bfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_hit,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              irq
);

    logic pending;
    logic enable;
    logic wr_stb, rd_stb, clr_req;
    logic [ADDR_W-1:0] rd_mux;

    assign wr_stb  = reg_sel && reg_wr;
    assign rd_stb  = reg_sel && !reg_wr;
    assign clr_req = wr_stb && (reg_off == OFF_STATUS) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (fault_hit)
            pending <= 1'b1;
        else if (clr_req)
            pending <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            enable <= 1'b0;
        else if (wr_stb && reg_off == OFF_ENABLE)
            enable <= reg_wdata[0];
    end

    always_comb begin
        case (reg_off)
            OFF_FADDR:  rd_mux = fault_addr;
            OFF_ENABLE: rd_mux = {{(ADDR_W-1){1'b0}}, enable};
            OFF_STATUS: rd_mux = {{(ADDR_W-1){1'b0}}, pending};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (rd_stb)
            reg_rdata <= rd_mux;
        else
            reg_rdata <= '0;
    end

    assign irq = pending && enable;

    // R8: a fault always leaves the flag set, even with a clear in the same cycle
    a_r8_fault_wins: assert property (@(posedge clk) disable iff (rst)
        fault_hit |=> pending);

    // R7: a clear without a concurrent fault drops the flag
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !fault_hit) |=> !pending);

    // R9: offset 3 reads zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && reg_off == 2'd3) |=> (reg_rdata == '0));

endmodule

// File: rtl/bfc_top.sv
module bfc_top
    import bfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_err,
    input  logic [31:0]        acc_addr,
    input  logic [1:0]         acc_kind,
    input  logic [2:0]         acc_bsize,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [1:0]         reg_off,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);

    fault_evt_t        evt;
    logic [ADDR_W-1:0] fault_addr;

    always_comb begin
        evt.hit   = acc_valid && acc_err;
        evt.addr  = acc_addr;
        evt.kind  = xfer_kind_e'(acc_kind);
        evt.bsize = acc_bsize;
    end

    bfc_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .fault_addr (fault_addr)
    );

    bfc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .fault_hit  (evt.hit),
        .fault_addr (fault_addr),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_off    (reg_off),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

endmodule

// File: tb/bfc_top_test.sv
`timescale 1ns/1ps
module bfc_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_err;
    logic [31:0] acc_addr;
    logic [1:0]  acc_kind;
    logic [2:0]  acc_bsize;
    logic        reg_sel, reg_wr;
    logic [1:0]  reg_off;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    bfc_top uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_err(acc_err),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_bsize(acc_bsize),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle();
        acc_valid = 0; acc_err = 0; reg_sel = 0; reg_wr = 0;
    endtask

    task automatic fault(input logic [31:0] a, input logic [1:0] k, input logic [2:0] b);
        acc_valid = 1; acc_err = 1; acc_addr = a; acc_kind = k; acc_bsize = b;
        cyc();
        idle();
    endtask

    task automatic rd(input logic [1:0] off, output logic [31:0] d);
        reg_sel = 1; reg_wr = 0; reg_off = off;
        cyc();
        d = reg_rdata;
        idle();
    endtask

    task automatic wr(input logic [1:0] off, input logic [31:0] d);
        reg_sel = 1; reg_wr = 1; reg_off = off; reg_wdata = d;
        cyc();
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] d, a, exp_a;
        idle();
        acc_addr = 0; acc_kind = 0; acc_bsize = 0; reg_off = 0; reg_wdata = 0;
        rst = 1;
        cyc(); cyc();
        rst = 0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rdata idle", reg_rdata, 0);
        rd(2'd0, d); chk("R1 faddr", d, 0);
        rd(2'd1, d); chk("R1 enable", d, 0);
        rd(2'd2, d); chk("R1 pending", d, 0);

        // R10 enable read back
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R10 enable set", d, 1);
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, d); chk("R10 enable clr", d, 0);

        // R9 unmapped and idle data
        rd(2'd3, d); chk("R9 unmapped", d, 0);
        cyc(); chk("R9 idle zero", reg_rdata, 0);

        // R2 exact capture for single, burst read and reserved codes
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 4; k++) begin
                if (k == 2) continue;
                a = 32'hA5C3_1F07 ^ (i * 32'h1357_9BDF) ^ (k * 32'h0F0F_0001);
                fault(a, 2'(k), 3'(i));
                rd(2'd0, d); chk("R2 exact", d, a);
            end
        end

        // R3 burst write masking across all burst sizes
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < 4; i++) begin
                a = 32'hFFFF_FFFF ^ (i * 32'h2468_ACE1);
                exp_a = a & ~((32'd1 << b) - 32'd1);
                fault(a, 2'd2, 3'(b));
                rd(2'd0, d); chk("R3 burst write mask", d, exp_a);
            end
        end
        fault(32'h1234_567F, 2'd2, 3'd4);
        rd(2'd0, d); chk("R3 16-byte burst", d, 32'h1234_5670);

        // R5 write to address register ignored
        wr(2'd0, 32'hDEAD_BEEF);
        rd(2'd0, d); chk("R5 ro", d, 32'h1234_5670);

        // R4 non-error and invalid accesses
        rd(2'd2, d);
        wr(2'd2, 1);
        rd(2'd2, d); chk("R7 clear", d, 0);
        acc_valid = 1; acc_err = 0; acc_addr = 32'h5555_5555; acc_kind = 0; cyc(); idle();
        acc_valid = 0; acc_err = 1; acc_addr = 32'h6666_6666; cyc(); idle();
        rd(2'd0, d); chk("R4 addr kept", d, 32'h1234_5670);
        rd(2'd2, d); chk("R4 pending kept", d, 0);

        // R6 pending and irq gating
        fault(32'h0000_1000, 2'd0, 3'd0);
        chk("R6 irq masked", {31'b0, irq}, 0);
        rd(2'd2, d); chk("R6 pending", d, 1);
        wr(2'd1, 1);
        chk("R6 irq on", {31'b0, irq}, 1);

        // R7 write zero keeps, write one clears
        wr(2'd2, 32'hFFFF_FFFE);
        chk("R7 zero keeps", {31'b0, irq}, 1);
        wr(2'd2, 1);
        chk("R7 one clears", {31'b0, irq}, 0);

        // R9 read returns pre-update value when fault coincides
        acc_valid = 1; acc_err = 1; acc_addr = 32'h0000_2000; acc_kind = 0;
        reg_sel = 1; reg_wr = 0; reg_off = 0;
        cyc(); d = reg_rdata; idle();
        chk("R9 old value", d, 32'h0000_1000);
        rd(2'd0, d); chk("R9 new value", d, 32'h0000_2000);

        // R8 fault and clear together
        wr(2'd2, 1);
        chk("R8 pre clear", {31'b0, irq}, 0);
        fault(32'h0000_3000, 2'd0, 3'd0);
        acc_valid = 1; acc_err = 1; acc_addr = 32'h0000_4004; acc_kind = 2; acc_bsize = 2;
        reg_sel = 1; reg_wr = 1; reg_off = 2; reg_wdata = 1;
        cyc(); idle();
        chk("R8 irq held", {31'b0, irq}, 1);
        rd(2'd2, d); chk("R8 pending held", d, 1);
        rd(2'd0, d); chk("R8 addr updated", d, 32'h0000_4004);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule